// File: doc/BRIEF.md
# Flash Command and Status Read Port

This block sits between a flash device's command register and its data bus. Each command byte written to it picks what later read cycles return: array data, the status byte or the identification codes. It also turns program and erase commands into one-cycle start requests for the embedded write engine. The write engine reports back through set and clear pulses on the upper four status bits. The program-fail and erase-fail bits are sticky. While one of them is set, the operations it guards are refused.

A read cycle runs while both active-low strobes, chip enable and output enable, are low. The status byte is captured once, on the first clock at which both strobes are seen low, which is when the later of the two falls. That captured copy stays on the bus until a strobe is raised again. The bus is 16 bits wide in word mode. In byte mode only the low eight lanes are driven.

Commands arrive on a plain `cmd_valid` qualifier with no back-pressure. A byte presented with `cmd_valid` high is taken on that clock edge, so a command can be written every cycle. All other pins are plain control or status levels and pulses.

Top module: `flash_status_port`

## Requirements
- R1: A command byte of FFh selects array reads, 70h selects status reads and 90h selects ID reads. Any byte that is not a listed code leaves the read mode unchanged. After reset the mode is array reads, and an array read drives `array_data` onto the driven lanes.
- R2: Any of the program command (41h), the sector erase command (20h) or the chip erase command (30h) switches later reads to status, even when the request itself is refused.
- R3: Status bit 4 (program fail) and bit 5 (erase fail) are set only by the write engine. Once set, each stays set until a clear command (50h) is written, or until reset or deep power-down exit. If the clear command and a set pulse for the same bit arrive in the same cycle, the bit ends up set.
- R4: `wsm_set[3:0]` sets status bits 7..4 and `wsm_clr[1:0]` clears bits 7..6. A set wins over a clear of the same bit in the same cycle.
- R5: In the cycle after a program command, `req_prog` pulses for one cycle only if bit 4 was clear. In the cycle after a sector or chip erase command, `req_sector_erase` or `req_chip_erase` pulses only if bit 5 was clear. At most one request is high in any cycle.
- R6: The status byte is captured on the first clock at which `ce_n` and `oe_n` are both seen low. It is held unchanged until a strobe rises, even if the status bits change in the meantime.
- R7: The status byte places bits 7..4 from the status register on lanes 7..4, the `sector_prot` input on lane 3, and zeros on lanes 2..0. Bit 3 is not affected by the clear command or by the write engine.
- R8: In word mode (`byte_mode`=0), a read cycle drives all 16 lanes, and a status read returns 00h on lanes 15..8.
- R9: In byte mode (`byte_mode`=1), a read cycle drives only lanes 7..0. Lanes 15..8 are released, leaving lane 15 free to act as the low address input.
- R10: After reset, and in the cycle after a `dpd_exit` pulse, status bits 7..4 equal 1000b.
- R11: In ID mode, `addr_lsb`=0 returns the manufacturer code and `addr_lsb`=1 returns the device code.
- R12: `dq_oe` is all zero in every cycle in which the registered read state shows no active read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dpd_exit | input | 1 | Pulse on return from deep power-down; restores status bits 7..4 |
| cmd_valid | input | 1 | Command byte qualifier; taken on the clock edge |
| cmd_byte | input | 8 | Command code |
| wsm_set | input | 4 | Write engine set pulses for status bits 7..4 ([3] is bit 7) |
| wsm_clr | input | 2 | Write engine clear pulses for status bits 7..6 ([1] is bit 7) |
| sector_prot | input | 1 | Sector-protect level shown on status bit 3 |
| req_prog | output | 1 | One-cycle page program start request |
| req_sector_erase | output | 1 | One-cycle sector erase start request |
| req_chip_erase | output | 1 | One-cycle chip erase start request |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| byte_mode | input | 1 | 1 selects the 8-bit bus, 0 the 16-bit bus |
| addr_lsb | input | 1 | Low address bit used by ID reads |
| array_data | input | 16 | Array read data from the stub |
| dq_out | output | 16 | Read data |
| dq_oe | output | 16 | Per-lane output enable |

## Verification
The bench applies directed stimulus and then random stimulus. Array reads with changing data separate pass-through from stale capture. Command sequences that mix listed and unlisted bytes show whether the read mode holds on unknown codes. Fail bits are set, then program and erase commands are written both before and after a clear, to check refusal and acceptance. Same-cycle collisions between set, clear and the clear command expose priority errors. Strobe orderings where either strobe falls last, combined with status changes during a held read, separate a per-cycle capture from a per-read-cycle capture.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_ID     = 2'd2
  } rmode_t;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_RD_ARRAY,
    CK_RD_STATUS,
    CK_CLR_STATUS,
    CK_RD_ID,
    CK_PROGRAM,
    CK_SECT_ERASE,
    CK_CHIP_ERASE
  } cmd_kind_t;

  localparam logic [7:0] OPC_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] OPC_RD_STATUS  = 8'h70;
  localparam logic [7:0] OPC_CLR_STATUS = 8'h50;
  localparam logic [7:0] OPC_RD_ID      = 8'h90;
  localparam logic [7:0] OPC_PROGRAM    = 8'h41;
  localparam logic [7:0] OPC_SECT_ERASE = 8'h20;
  localparam logic [7:0] OPC_CHIP_ERASE = 8'h30;

  // status bits 7..4 after power-up / deep power-down exit (index 3 = bit 7)
  localparam logic [3:0] ST_RESET_VAL = 4'b1000;

  function automatic cmd_kind_t classify(input logic [7:0] b);
    cmd_kind_t k;
    case (b)
      OPC_RD_ARRAY:   k = CK_RD_ARRAY;
      OPC_RD_STATUS:  k = CK_RD_STATUS;
      OPC_CLR_STATUS: k = CK_CLR_STATUS;
      OPC_RD_ID:      k = CK_RD_ID;
      OPC_PROGRAM:    k = CK_PROGRAM;
      OPC_SECT_ERASE: k = CK_SECT_ERASE;
      OPC_CHIP_ERASE: k = CK_CHIP_ERASE;
      default:        k = CK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       prog_fail,
  input  logic       erase_fail,
  output rmode_t     mode,
  output logic       clr_fail,
  output logic       req_prog,
  output logic       req_serase,
  output logic       req_cerase
);

  cmd_kind_t kind;

  always_comb begin
    kind     = classify(cmd_byte);
    clr_fail = cmd_valid && (kind == CK_CLR_STATUS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= RM_ARRAY;
      req_prog   <= 1'b0;
      req_serase <= 1'b0;
      req_cerase <= 1'b0;
    end else begin
      req_prog   <= 1'b0;
      req_serase <= 1'b0;
      req_cerase <= 1'b0;
      if (cmd_valid) begin
        case (kind)
          CK_RD_ARRAY:  mode <= RM_ARRAY;
          CK_RD_STATUS: mode <= RM_STATUS;
          CK_RD_ID:     mode <= RM_ID;
          CK_PROGRAM: begin
            mode     <= RM_STATUS;
            req_prog <= !prog_fail;
          end
          CK_SECT_ERASE: begin
            mode       <= RM_STATUS;
            req_serase <= !erase_fail;
          end
          CK_CHIP_ERASE: begin
            mode       <= RM_STATUS;
            req_cerase <= !erase_fail;
          end
          default: ;
        endcase
      end
    end
  end

  assert_req_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_prog, req_serase, req_cerase}));

  assert_prog_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |-> $past(!prog_fail));

  assert_erase_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_serase || req_cerase) |-> $past(!erase_fail));

  assert_mode_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(mode));

endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
  import fsr_pkg::*;
#(
  parameter int N_BITS  = 4,
  parameter int N_WSMCL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dpd_exit,
  input  logic               clr_fail,
  input  logic [N_BITS-1:0]  wsm_set,
  input  logic [N_WSMCL-1:0] wsm_clr,
  output logic [N_BITS-1:0]  st
);

  localparam int FIRST_WSMCL = N_BITS - N_WSMCL;

  // index 0 = program fail (bit 4), 1 = erase fail (bit 5), 2..3 = bits 6..7
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    logic drop;
    if (i >= FIRST_WSMCL) begin : g_wsm_clear
      assign drop = wsm_clr[i-FIRST_WSMCL];
    end else begin : g_sticky
      assign drop = clr_fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             st[i] <= ST_RESET_VAL[i];
      else if (dpd_exit)      st[i] <= ST_RESET_VAL[i];
      else if (wsm_set[i])    st[i] <= 1'b1;
      else if (drop)          st[i] <= 1'b0;
    end
  end

  assert_pfail_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st[0]) |-> $past(clr_fail || dpd_exit));

  assert_efail_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st[1]) |-> $past(clr_fail || dpd_exit));

  assert_efail_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[1]) |-> $past(wsm_set[1]));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd_exit && wsm_set[3] && wsm_clr[1]) |=> st[3]);

  assert_dpd_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_exit |=> (st == 4'b1000));

endmodule

// File: rtl/fsr_snapshot.sv
module fsr_snapshot #(
  parameter int SB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic [SB_W-1:0] status_byte,
  output logic            rd_q,
  output logic [SB_W-1:0] snap
);

  logic rd_now;
  logic rd_start;

  always_comb begin
    rd_now   = !ce_n && !oe_n;
    rd_start = rd_now && !rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      snap <= '0;
    end else begin
      rd_q <= rd_now;
      if (rd_start) snap <= status_byte;
    end
  end

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && $past(rd_q)) |-> $stable(snap));

  assert_read_tracks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> !rd_q);

endmodule

// File: rtl/fsr_bus_fmt.sv
module fsr_bus_fmt
  import fsr_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          LO_W     = 8,
  parameter logic [15:0] MFR_CODE = 16'h00A7,
  parameter logic [15:0] DEV_CODE = 16'h22D4
) (
  input  rmode_t            mode,
  input  logic              rd_q,
  input  logic [LO_W-1:0]   snap,
  input  logic              byte_mode,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe
);

  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] lane_en;

  always_comb begin
    case (mode)
      RM_STATUS: word = {{HI_W{1'b0}}, snap};
      RM_ID:     word = addr_lsb ? DEV_CODE[DATA_W-1:0] : MFR_CODE[DATA_W-1:0];
      default:   word = array_data;
    endcase
  end

  for (genvar l = 0; l < DATA_W; l++) begin : g_lane
    if (l < LO_W) begin : g_lo
      assign lane_en[l] = rd_q;
    end else begin : g_hi
      assign lane_en[l] = rd_q && !byte_mode;
    end
  end

  assign dq_oe  = lane_en;
  assign dq_out = word & lane_en;

  always_comb begin
    if (rd_q && mode == RM_STATUS)
      assert_status_low_lanes_R7: assert (dq_out[2:0] == 3'b000);
  end

endmodule

// File: rtl/flash_status_port.sv
module flash_status_port
  import fsr_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00A7,
  parameter logic [15:0] DEV_CODE = 16'h22D4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dpd_exit,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic [3:0]        wsm_set,
  input  logic [1:0]        wsm_clr,
  input  logic              sector_prot,
  output logic              req_prog,
  output logic              req_sector_erase,
  output logic              req_chip_erase,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              byte_mode,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe
);

  localparam int SB_W   = 8;
  localparam int N_ST   = 4;
  localparam int N_WSMC = 2;

  rmode_t          mode;
  logic            clr_fail;
  logic [N_ST-1:0] st;
  logic [SB_W-1:0] status_byte;
  logic            rd_q;
  logic [SB_W-1:0] snap;

  assign status_byte = {st, sector_prot, 3'b000};

  fsr_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .prog_fail  (st[0]),
    .erase_fail (st[1]),
    .mode       (mode),
    .clr_fail   (clr_fail),
    .req_prog   (req_prog),
    .req_serase (req_sector_erase),
    .req_cerase (req_chip_erase)
  );

  fsr_status_reg #(.N_BITS(N_ST), .N_WSMCL(N_WSMC)) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .dpd_exit (dpd_exit),
    .clr_fail (clr_fail),
    .wsm_set  (wsm_set),
    .wsm_clr  (wsm_clr),
    .st       (st)
  );

  fsr_snapshot #(.SB_W(SB_W)) u_snap (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .status_byte (status_byte),
    .rd_q        (rd_q),
    .snap        (snap)
  );

  fsr_bus_fmt #(
    .DATA_W   (DATA_W),
    .LO_W     (SB_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_fmt (
    .mode       (mode),
    .rd_q       (rd_q),
    .snap       (snap),
    .byte_mode  (byte_mode),
    .addr_lsb   (addr_lsb),
    .array_data (array_data),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

  assert_auto_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prog || req_sector_erase || req_chip_erase) |-> (mode == RM_STATUS));

endmodule

// File: tb/sim_flash_status_port.sv
`timescale 1ns/1ps
module sim_flash_status_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dpd_exit = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic [3:0]  wsm_set = 4'h0;
  logic [1:0]  wsm_clr = 2'b00;
  logic        sector_prot = 1'b0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        byte_mode = 1'b0;
  logic        addr_lsb = 1'b0;
  logic [15:0] array_data = 16'h0000;
  logic        req_prog, req_sector_erase, req_chip_erase;
  logic [15:0] dq_out, dq_oe;

  localparam logic [15:0] MFR = 16'h00A7;
  localparam logic [15:0] DEV = 16'h22D4;

  always #2.5 clk = ~clk;

  flash_status_port u0 (
    .clk(clk), .rst_n(rst_n), .dpd_exit(dpd_exit),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wsm_set(wsm_set), .wsm_clr(wsm_clr), .sector_prot(sector_prot),
    .req_prog(req_prog), .req_sector_erase(req_sector_erase),
    .req_chip_erase(req_chip_erase),
    .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode), .addr_lsb(addr_lsb),
    .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // behavioural reference model
  int         m_mode;   // 0 array, 1 status, 2 id
  logic [3:0] m_st;
  bit         m_rd;
  logic [7:0] m_snap;
  logic [2:0] m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_st = 4'b1000; m_rd = 0; m_snap = 8'h00; m_req = 3'b000;
    end else begin
      bit rd_now;
      bit clr;
      logic [3:0] nst;
      rd_now = !ce_n && !oe_n;
      if (rd_now && !m_rd) m_snap = {m_st, sector_prot, 3'b000};
      m_rd  = rd_now;
      m_req = 3'b000;
      clr   = 0;
      if (cmd_valid) begin
        case (cmd_byte)
          8'hFF: m_mode = 0;
          8'h70: m_mode = 1;
          8'h90: m_mode = 2;
          8'h50: clr = 1;
          8'h41: begin m_mode = 1; m_req[0] = !m_st[0]; end
          8'h20: begin m_mode = 1; m_req[1] = !m_st[1]; end
          8'h30: begin m_mode = 1; m_req[2] = !m_st[1]; end
          default: ;
        endcase
      end
      if (dpd_exit) m_st = 4'b1000;
      else begin
        nst = m_st;
        if (clr) nst[1:0] = 2'b00;
        nst[3:2] = nst[3:2] & ~wsm_clr;
        nst = nst | wsm_set;
        m_st = nst;
      end
    end
  end

  int    n_vec = 0;
  int    n_bad = 0;
  string ph = "R10";
  bit    done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [15:0] e_oe, e_dq;
    @(posedge clk);
    @(negedge clk);
    e_oe = m_rd ? (byte_mode ? 16'h00FF : 16'hFFFF) : 16'h0000;
    case (m_mode)
      1:       e_dq = {8'h00, m_snap};
      2:       e_dq = addr_lsb ? DEV : MFR;
      default: e_dq = array_data;
    endcase
    chk(ph, "dq_oe", dq_oe, e_oe);
    chk(ph, "dq_out", dq_out & e_oe, e_dq & e_oe);
    chk(ph, "req", {13'd0, req_chip_erase, req_sector_erase, req_prog}, {13'd0, m_req});
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_byte = b; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0; tick();
  endtask

  task automatic rd(input int n);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (n) tick();
    ce_n = 1'b1; oe_n = 1'b1; tick();
  endtask

  task automatic wsm(input logic [3:0] s, input logic [1:0] c);
    wsm_set = s; wsm_clr = c; tick(); wsm_set = 4'h0; wsm_clr = 2'b00; tick();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in phase %s", ph);
      summary();
      $finish;
    end
  end

  initial begin
    ph = "R10";
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();

    ph = "R1";
    array_data = 16'hA5C3;
    ce_n = 0; oe_n = 0; tick(); tick();
    array_data = 16'h1234; tick();
    ce_n = 1; oe_n = 1; tick();
    cmd(8'h12); rd(2);
    cmd(8'h70); rd(2);
    cmd(8'h13); rd(2);
    cmd(8'h90); rd(1);
    cmd(8'hFF); array_data = 16'h5AA5; rd(2);

    ph = "R7";
    cmd(8'h70);
    sector_prot = 1; rd(2);
    cmd(8'h50); rd(1);
    wsm(4'hF, 2'b00); rd(1);
    sector_prot = 0; rd(1);

    ph = "R4";
    wsm(4'h0, 2'b11); rd(1);
    wsm(4'b0100, 2'b01); rd(1);
    wsm(4'b1000, 2'b10); rd(1);
    wsm(4'b0000, 2'b10); rd(1);

    ph = "R3";
    cmd(8'h50); rd(1);
    wsm(4'b0001, 2'b00); rd(1);
    cmd(8'h70); rd(1);
    wsm(4'b0000, 2'b11); rd(1);
    cmd(8'h50); rd(1);
    wsm_set = 4'b0010; cmd_byte = 8'h50; cmd_valid = 1; tick();
    wsm_set = 4'b0000; cmd_valid = 0; tick(); rd(1);

    ph = "R5";
    wsm(4'b0001, 2'b00);
    cmd(8'h41); cmd(8'h20); cmd(8'h30);
    cmd(8'h50);
    cmd(8'h41); cmd(8'h20); cmd(8'h30);
    wsm(4'b0010, 2'b00);
    cmd(8'h41); cmd(8'h20); cmd(8'h30); rd(1);

    ph = "R2";
    cmd(8'h50);
    cmd(8'hFF); array_data = 16'hBEEF; cmd(8'h41); rd(1);
    cmd(8'hFF); cmd(8'h20); rd(1);
    cmd(8'hFF); cmd(8'h30); rd(1);

    ph = "R6";
    cmd(8'h70);
    oe_n = 0; tick();
    wsm_clr = 2'b10; tick(); wsm_clr = 2'b00;
    ce_n = 0; tick();
    wsm_set = 4'b1100; tick(); wsm_set = 4'h0; tick(); tick();
    oe_n = 1; tick(); oe_n = 0; tick(); tick();
    ce_n = 1; tick();
    wsm_set = 4'b0011; tick(); wsm_set = 4'h0;
    ce_n = 0; tick(); tick();
    oe_n = 1; ce_n = 1; tick();

    ph = "R8";
    byte_mode = 0; rd(2);
    ph = "R9";
    byte_mode = 1; rd(2);
    cmd(8'hFF); array_data = 16'hF00D; rd(2);
    byte_mode = 0;

    ph = "R11";
    cmd(8'h90);
    addr_lsb = 0; rd(1);
    addr_lsb = 1; rd(1);
    byte_mode = 1; rd(1); byte_mode = 0;

    ph = "R12";
    ce_n = 0; oe_n = 1; tick(); tick();
    ce_n = 1; oe_n = 0; tick(); tick();
    oe_n = 1; tick();

    ph = "R10";
    cmd(8'h70);
    wsm(4'b0111, 2'b00);
    dpd_exit = 1; tick(); dpd_exit = 0; tick(); rd(2);

    ph = "R7";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      cmd_valid = (r < 5);
      case ($urandom_range(0, 8))
        0: cmd_byte = 8'hFF; 1: cmd_byte = 8'h70; 2: cmd_byte = 8'h50;
        3: cmd_byte = 8'h90; 4: cmd_byte = 8'h41; 5: cmd_byte = 8'h20;
        6: cmd_byte = 8'h30; default: cmd_byte = 8'($urandom);
      endcase
      wsm_set     = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      wsm_clr     = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      dpd_exit    = ($urandom_range(0, 60) == 0);
      ce_n        = ($urandom_range(0, 2) == 0);
      oe_n        = ($urandom_range(0, 2) == 0);
      byte_mode   = ($urandom_range(0, 5) == 0);
      addr_lsb    = 1'($urandom);
      sector_prot = ($urandom_range(0, 7) == 0) ? ~sector_prot : sector_prot;
      array_data  = 16'($urandom);
      tick();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule